// File: doc/BRIEF.md
# Pin I/O Controller Register Bank

This block is the register front end for one port of up to 32 general-purpose pins. Software reaches it over a plain 32-bit register bus: address, write strobe with write data, and read strobe with read data that is combinational while the read strobe is high. Every pin attribute has a write-one-to-set register, a write-one-to-clear register and a read-only status register. Each pin can be a software-driven input, a software-driven output, or be handed to one of four peripheral functions through two per-pin select registers.

The block drives the per-pin pad controls: output enable, output value, open-drain, pull-up, pull-down, glitch-filter enable, Schmitt enable, PIO ownership and a 2-bit peripheral select. The pad inputs pass through a two-flop synchroniser before software can read them. Pull-up and pull-down are interlocked in hardware. A key-guarded protection register can freeze the configuration while leaving the output data writable, and a clear-on-read status register records the last refused write.

Top module: `pin_ctrl_bank`

## Requirements
- R1: After reset every pin is PIO-owned, output enable is off, pull-up is on, pull-down, filter, open-drain, Schmitt and output data are off, both select registers are zero and protection is off.
- R2: For the ownership (0x00/0x04/0x08), output enable (0x10/0x14/0x18), filter (0x40/0x44/0x48) and open-drain (0x50/0x54/0x58) triplets, a 1 in the set register sets the pin's bit and a 1 in the clear register clears it, zero bits leave pins unchanged, the status register returns the bits; select-1 (0x70), select-2 (0x74) and Schmitt (0x78) are plain read/write. Writes take effect at the edge that ends the write cycle.
- R3: Output data is set through 0x60 and cleared through 0x64, with status at 0x68 and on `padOut`; these writes are honoured even while protection is on.
- R4: A read of 0x7C returns the pad input as sampled by two flip-flops, so a pad change is visible from the second rising edge after it.
- R5: `periphSel[2i+1:2i]` is {select-2 bit i, select-1 bit i}: A = 00, B = 01, C = 10, D = 11.
- R6: `pioOwn` is the ownership status; a pin not owned by the PIO has `padOe` low, and an owned pin drives `padOe` from its output-enable bit.
- R7: Pull-up (0x20/0x24/0x28) and pull-down (0x30/0x34/0x38) never both are on for a pin: setting one clears the other for the same pins in the same cycle.
- R8: The protection register at 0x80 takes the enable from bit 0 only when bits [31:8] equal the key (default 0xA5C3E1); a wrong-key write leaves it unchanged. Reading it returns the enable in bit 0.
- R9: While protection is on, writes to every configuration register other than output data are refused. A refused write, or a wrong-key write to 0x80, sets bit 0 and stores the byte address in bits [15:8] of the status at 0x84, which clears to zero after it is read.
- R10: With open-drain on, a pin whose output data is 1 has `padOe` low; with output data 0 it drives low if owned and enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write strobe |
| rdEn | input | 1 | Read strobe |
| addr | input | 8 | Byte address |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, valid while rdEn is high, zero otherwise |
| padIn | input | NPINS | Raw pad input levels |
| padOe | output | NPINS | Pad output enable from the PIO |
| padOut | output | NPINS | Pad output value (output data) |
| openDrain | output | NPINS | Open-drain mode per pin |
| pullUp | output | NPINS | Pull-up enable |
| pullDown | output | NPINS | Pull-down enable |
| filterEn | output | NPINS | Glitch-filter enable |
| schmittEn | output | NPINS | Schmitt trigger enable |
| pioOwn | output | NPINS | 1 where the PIO owns the pad, 0 where the peripheral does |
| periphSel | output | 2*NPINS | Peripheral function per pin |

## Verification
Register writes land on the edge that closes the write cycle, so every pad control and status is due one cycle after the write; reads and the pad-control decode are combinational, and the pad input needs two rising edges before the level register shows it. The bench keeps a behavioural model that applies each bus cycle on the same edge the design does, with its own two-stage delay for the pad input, and compares every output and every read value at the falling edge, half a cycle away from the edges where results change. The clear-on-read status is modelled the same way: the read returns the old value and the next read returns zero.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;
  localparam int ADDR_W = 8;

  localparam logic [ADDR_W-1:0] A_CTL_SET  = 8'h00;
  localparam logic [ADDR_W-1:0] A_CTL_CLR  = 8'h04;
  localparam logic [ADDR_W-1:0] A_CTL_STAT = 8'h08;
  localparam logic [ADDR_W-1:0] A_OE_SET   = 8'h10;
  localparam logic [ADDR_W-1:0] A_OE_CLR   = 8'h14;
  localparam logic [ADDR_W-1:0] A_OE_STAT  = 8'h18;
  localparam logic [ADDR_W-1:0] A_PU_SET   = 8'h20;
  localparam logic [ADDR_W-1:0] A_PU_CLR   = 8'h24;
  localparam logic [ADDR_W-1:0] A_PU_STAT  = 8'h28;
  localparam logic [ADDR_W-1:0] A_PD_SET   = 8'h30;
  localparam logic [ADDR_W-1:0] A_PD_CLR   = 8'h34;
  localparam logic [ADDR_W-1:0] A_PD_STAT  = 8'h38;
  localparam logic [ADDR_W-1:0] A_FL_SET   = 8'h40;
  localparam logic [ADDR_W-1:0] A_FL_CLR   = 8'h44;
  localparam logic [ADDR_W-1:0] A_FL_STAT  = 8'h48;
  localparam logic [ADDR_W-1:0] A_OD_SET   = 8'h50;
  localparam logic [ADDR_W-1:0] A_OD_CLR   = 8'h54;
  localparam logic [ADDR_W-1:0] A_OD_STAT  = 8'h58;
  localparam logic [ADDR_W-1:0] A_OUT_SET  = 8'h60;
  localparam logic [ADDR_W-1:0] A_OUT_CLR  = 8'h64;
  localparam logic [ADDR_W-1:0] A_OUT_STAT = 8'h68;
  localparam logic [ADDR_W-1:0] A_SEL1     = 8'h70;
  localparam logic [ADDR_W-1:0] A_SEL2     = 8'h74;
  localparam logic [ADDR_W-1:0] A_SMT      = 8'h78;
  localparam logic [ADDR_W-1:0] A_LEVEL    = 8'h7C;
  localparam logic [ADDR_W-1:0] A_WP_MODE  = 8'h80;
  localparam logic [ADDR_W-1:0] A_WP_STAT  = 8'h84;

  // Write strobes from the control to the datapath
  typedef struct packed {
    logic ctlSet, ctlClr;
    logic oeSet, oeClr;
    logic puSet, puClr;
    logic pdSet, pdClr;
    logic flSet, flClr;
    logic odSet, odClr;
    logic outSet, outClr;
    logic sel1Wr, sel2Wr, smtWr;
  } strobe_t;
endpackage

// File: rtl/pinctl_ctrl.sv
module pinctl_ctrl
  import pinctl_pkg::*;
#(
  parameter logic [23:0] WP_KEY = 24'hA5C3E1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [23:0]       wrKey,
  input  logic              wrLsb,
  output strobe_t           stb,
  output logic              wpOn,
  output logic [31:0]       ctrlRd
);
  logic              viol;
  logic [ADDR_W-1:0] violAddr;
  logic              isCfg;
  logic              cfgOk;
  logic              keyOk;
  logic              blocked;

  always_comb begin
    unique case (addr)
      A_CTL_SET, A_CTL_CLR, A_OE_SET, A_OE_CLR, A_PU_SET, A_PU_CLR,
      A_PD_SET, A_PD_CLR, A_FL_SET, A_FL_CLR, A_OD_SET, A_OD_CLR,
      A_SEL1, A_SEL2, A_SMT: isCfg = 1'b1;
      default:               isCfg = 1'b0;
    endcase
  end

  assign keyOk   = (wrKey == WP_KEY);
  assign cfgOk   = wrEn && !wpOn;
  assign blocked = wrEn && ((isCfg && wpOn) || (addr == A_WP_MODE && !keyOk));

  always_comb begin
    stb        = '0;
    stb.ctlSet = cfgOk && addr == A_CTL_SET;
    stb.ctlClr = cfgOk && addr == A_CTL_CLR;
    stb.oeSet  = cfgOk && addr == A_OE_SET;
    stb.oeClr  = cfgOk && addr == A_OE_CLR;
    stb.puSet  = cfgOk && addr == A_PU_SET;
    stb.puClr  = cfgOk && addr == A_PU_CLR;
    stb.pdSet  = cfgOk && addr == A_PD_SET;
    stb.pdClr  = cfgOk && addr == A_PD_CLR;
    stb.flSet  = cfgOk && addr == A_FL_SET;
    stb.flClr  = cfgOk && addr == A_FL_CLR;
    stb.odSet  = cfgOk && addr == A_OD_SET;
    stb.odClr  = cfgOk && addr == A_OD_CLR;
    stb.sel1Wr = cfgOk && addr == A_SEL1;
    stb.sel2Wr = cfgOk && addr == A_SEL2;
    stb.smtWr  = cfgOk && addr == A_SMT;
    stb.outSet = wrEn && addr == A_OUT_SET;
    stb.outClr = wrEn && addr == A_OUT_CLR;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wpOn     <= 1'b0;
      viol     <= 1'b0;
      violAddr <= '0;
    end else begin
      if (wrEn && addr == A_WP_MODE && keyOk) wpOn <= wrLsb;
      if (blocked) begin
        viol     <= 1'b1;
        violAddr <= addr;
      end else if (rdEn && addr == A_WP_STAT) begin
        viol     <= 1'b0;
        violAddr <= '0;
      end
    end
  end

  always_comb begin
    ctrlRd = '0;
    if (addr == A_WP_MODE) ctrlRd = {31'b0, wpOn};
    if (addr == A_WP_STAT) ctrlRd = {16'b0, violAddr, 7'b0, viol};
  end
endmodule

// File: rtl/pinctl_dp.sv
module pinctl_dp
  import pinctl_pkg::*;
#(
  parameter int NPINS = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  strobe_t            stb,
  input  logic [NPINS-1:0]   wrBits,
  input  logic [ADDR_W-1:0]  addr,
  input  logic [NPINS-1:0]   padIn,
  output logic [31:0]        dpRd,
  output logic [NPINS-1:0]   padOe,
  output logic [NPINS-1:0]   padOut,
  output logic [NPINS-1:0]   openDrain,
  output logic [NPINS-1:0]   pullUp,
  output logic [NPINS-1:0]   pullDown,
  output logic [NPINS-1:0]   filterEn,
  output logic [NPINS-1:0]   schmittEn,
  output logic [NPINS-1:0]   pioOwn,
  output logic [2*NPINS-1:0] periphSel
);
  localparam int PADW = 32 - NPINS;

  logic [NPINS-1:0] ctlQ, oeQ, puQ, pdQ, flQ, odQ, outQ, sel1Q, sel2Q, smtQ;
  logic [NPINS-1:0] syncA, syncB;

  function automatic logic [NPINS-1:0] setClr(input logic [NPINS-1:0] cur,
      input logic s, input logic c, input logic [NPINS-1:0] d);
    return (cur | (s ? d : '0)) & ~(c ? d : '0);
  endfunction

  function automatic logic [31:0] ext(input logic [NPINS-1:0] v);
    return {{PADW{1'b0}}, v};
  endfunction

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctlQ  <= '1;
      oeQ   <= '0;
      puQ   <= '1;
      pdQ   <= '0;
      flQ   <= '0;
      odQ   <= '0;
      outQ  <= '0;
      sel1Q <= '0;
      sel2Q <= '0;
      smtQ  <= '0;
      syncA <= '0;
      syncB <= '0;
    end else begin
      ctlQ  <= setClr(ctlQ, stb.ctlSet, stb.ctlClr, wrBits);
      oeQ   <= setClr(oeQ, stb.oeSet, stb.oeClr, wrBits);
      flQ   <= setClr(flQ, stb.flSet, stb.flClr, wrBits);
      odQ   <= setClr(odQ, stb.odSet, stb.odClr, wrBits);
      outQ  <= setClr(outQ, stb.outSet, stb.outClr, wrBits);
      // pull interlock: setting one side clears the other side
      puQ   <= setClr(puQ, stb.puSet, stb.puClr || stb.pdSet, wrBits);
      pdQ   <= setClr(pdQ, stb.pdSet, stb.pdClr || stb.puSet, wrBits);
      if (stb.sel1Wr) sel1Q <= wrBits;
      if (stb.sel2Wr) sel2Q <= wrBits;
      if (stb.smtWr)  smtQ  <= wrBits;
      syncA <= padIn;
      syncB <= syncA;
    end
  end

  assign padOe     = ctlQ & oeQ & ~(odQ & outQ);
  assign padOut    = outQ;
  assign openDrain = odQ;
  assign pullUp    = puQ;
  assign pullDown  = pdQ;
  assign filterEn  = flQ;
  assign schmittEn = smtQ;
  assign pioOwn    = ctlQ;

  for (genvar i = 0; i < NPINS; i++) begin : g_sel
    assign periphSel[2*i+1:2*i] = {sel2Q[i], sel1Q[i]};
  end

  always_comb begin
    unique case (addr)
      A_CTL_STAT: dpRd = ext(ctlQ);
      A_OE_STAT:  dpRd = ext(oeQ);
      A_PU_STAT:  dpRd = ext(puQ);
      A_PD_STAT:  dpRd = ext(pdQ);
      A_FL_STAT:  dpRd = ext(flQ);
      A_OD_STAT:  dpRd = ext(odQ);
      A_OUT_STAT: dpRd = ext(outQ);
      A_SEL1:     dpRd = ext(sel1Q);
      A_SEL2:     dpRd = ext(sel2Q);
      A_SMT:      dpRd = ext(smtQ);
      A_LEVEL:    dpRd = ext(syncB);
      default:    dpRd = '0;
    endcase
  end
endmodule

// File: rtl/pin_ctrl_bank.sv
module pin_ctrl_bank
  import pinctl_pkg::*;
#(
  parameter int          NPINS  = 32,
  parameter logic [23:0] WP_KEY = 24'hA5C3E1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               wrEn,
  input  logic               rdEn,
  input  logic [7:0]         addr,
  input  logic [31:0]        wrData,
  output logic [31:0]        rdData,
  input  logic [NPINS-1:0]   padIn,
  output logic [NPINS-1:0]   padOe,
  output logic [NPINS-1:0]   padOut,
  output logic [NPINS-1:0]   openDrain,
  output logic [NPINS-1:0]   pullUp,
  output logic [NPINS-1:0]   pullDown,
  output logic [NPINS-1:0]   filterEn,
  output logic [NPINS-1:0]   schmittEn,
  output logic [NPINS-1:0]   pioOwn,
  output logic [2*NPINS-1:0] periphSel
);
  strobe_t     stb;
  logic        wpOn;
  logic [31:0] ctrlRd;
  logic [31:0] dpRd;

  pinctl_ctrl #(.WP_KEY(WP_KEY)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrKey(wrData[31:8]), .wrLsb(wrData[0]),
    .stb(stb), .wpOn(wpOn), .ctrlRd(ctrlRd)
  );

  pinctl_dp #(.NPINS(NPINS)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .wrBits(wrData[NPINS-1:0]),
    .addr(addr), .padIn(padIn), .dpRd(dpRd),
    .padOe(padOe), .padOut(padOut), .openDrain(openDrain),
    .pullUp(pullUp), .pullDown(pullDown), .filterEn(filterEn),
    .schmittEn(schmittEn), .pioOwn(pioOwn), .periphSel(periphSel)
  );

  assign rdData = rdEn ? (ctrlRd | dpRd) : '0;
endmodule

// File: rtl/pinctl_chk.sv
module pinctl_chk
  import pinctl_pkg::*;
#(
  parameter int NPINS = 32
) (
  input logic             clk,
  input logic             rstN,
  input logic             wrEn,
  input logic [7:0]       addr,
  input logic [31:0]      wrData,
  input logic             wpOn,
  input logic [NPINS-1:0] pullUp,
  input logic [NPINS-1:0] pullDown,
  input logic [NPINS-1:0] padOe,
  input logic [NPINS-1:0] padOut,
  input logic [NPINS-1:0] pioOwn,
  input logic [NPINS-1:0] openDrain
);
  AST_PULL_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (pullUp & pullDown) == '0); // R7

  AST_PERIPH_NO_OE: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & ~pioOwn) == '0); // R6

  AST_OD_HIGH_RELEASED: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & openDrain & padOut) == '0); // R10

  AST_PROTECT_HOLDS_PULL: assert property (@(posedge clk) disable iff (!rstN)
    (wpOn && wrEn && (addr == A_PU_CLR || addr == A_PD_SET)) |=> $stable(pullUp)); // R9

  AST_OUT_SET_LANDS: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == A_OUT_SET) |=>
      ((padOut & $past(wrData[NPINS-1:0])) == $past(wrData[NPINS-1:0]))); // R3
endmodule

bind pin_ctrl_bank pinctl_chk #(.NPINS(NPINS)) u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .wpOn(wpOn), .pullUp(pullUp), .pullDown(pullDown), .padOe(padOe),
  .padOut(padOut), .pioOwn(pioOwn), .openDrain(openDrain)
);

// File: tb/test_pin_ctrl_bank.sv
module test_pin_ctrl_bank;
  localparam int CLK_PERIOD = 10;
  localparam int N = 32;
  localparam logic [23:0] KEY = 24'hA5C3E1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          rdEn = 1'b0;
  logic [7:0]    addr = '0;
  logic [31:0]   wrData = '0;
  logic [31:0]   rdData;
  logic [N-1:0]  padIn = '0;
  logic [N-1:0]  padOe, padOut, openDrain, pullUp, pullDown;
  logic [N-1:0]  filterEn, schmittEn, pioOwn;
  logic [2*N-1:0] periphSel;

  int checks = 0;
  int fails  = 0;

  pin_ctrl_bank i_pin_ctrl_bank (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .padIn(padIn), .padOe(padOe),
    .padOut(padOut), .openDrain(openDrain), .pullUp(pullUp),
    .pullDown(pullDown), .filterEn(filterEn), .schmittEn(schmittEn),
    .pioOwn(pioOwn), .periphSel(periphSel)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // behavioural model state
  logic [31:0] mOwn, mOe, mPu, mPd, mFl, mOd, mOut, mS1, mS2, mSmt;
  logic [31:0] padDly [$];
  logic        mWp, mViol;
  logic [7:0]  mVAddr;

  function automatic bit isCfgAddr(logic [7:0] a);
    return a inside {8'h00, 8'h04, 8'h10, 8'h14, 8'h20, 8'h24, 8'h30, 8'h34,
                     8'h40, 8'h44, 8'h50, 8'h54, 8'h70, 8'h74, 8'h78};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mOwn = '1; mOe = '0; mPu = '1; mPd = '0; mFl = '0; mOd = '0;
      mOut = '0; mS1 = '0; mS2 = '0; mSmt = '0;
      mWp = 1'b0; mViol = 1'b0; mVAddr = '0;
      padDly = '{32'h0, 32'h0};
    end else begin
      void'(padDly.pop_front());
      padDly.push_back(padIn);
      if (rdEn && addr == 8'h84) begin mViol = 1'b0; mVAddr = '0; end
      if (wrEn) begin
        if ((isCfgAddr(addr) && mWp) || (addr == 8'h80 && wrData[31:8] != KEY)) begin
          mViol = 1'b1; mVAddr = addr;
        end else begin
          case (addr)
            8'h00: mOwn |= wrData;  8'h04: mOwn &= ~wrData;
            8'h10: mOe  |= wrData;  8'h14: mOe  &= ~wrData;
            8'h20: begin mPu |= wrData; mPd &= ~wrData; end
            8'h24: mPu &= ~wrData;
            8'h30: begin mPd |= wrData; mPu &= ~wrData; end
            8'h34: mPd &= ~wrData;
            8'h40: mFl  |= wrData;  8'h44: mFl  &= ~wrData;
            8'h50: mOd  |= wrData;  8'h54: mOd  &= ~wrData;
            8'h60: mOut |= wrData;  8'h64: mOut &= ~wrData;
            8'h70: mS1 = wrData;    8'h74: mS2 = wrData;
            8'h78: mSmt = wrData;
            8'h80: mWp = wrData[0];
            default: ;
          endcase
        end
      end
    end
  end

  function automatic logic [31:0] mRead(logic [7:0] a);
    case (a)
      8'h08: return mOwn;  8'h18: return mOe;   8'h28: return mPu;
      8'h38: return mPd;   8'h48: return mFl;   8'h58: return mOd;
      8'h68: return mOut;  8'h70: return mS1;   8'h74: return mS2;
      8'h78: return mSmt;  8'h7C: return padDly[0];
      8'h80: return {31'b0, mWp};
      8'h84: return {16'b0, mVAddr, 7'b0, mViol};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string req, string what, logic [63:0] got, logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, got, exp);
    end
  endtask

  // compare every cycle at the falling edge
  always @(negedge clk) begin
    if (rstN) begin
      logic [63:0] sel;
      for (int i = 0; i < N; i++) sel[2*i +: 2] = {mS2[i], mS1[i]};
      chk("R6", "pioOwn", 64'(pioOwn), 64'(mOwn));
      chk("R10", "padOe", 64'(padOe), 64'(mOwn & mOe & ~(mOd & mOut)));
      chk("R3", "padOut", 64'(padOut), 64'(mOut));
      chk("R7", "pullUp", 64'(pullUp), 64'(mPu));
      chk("R7", "pullDown", 64'(pullDown), 64'(mPd));
      chk("R2", "filterEn", 64'(filterEn), 64'(mFl));
      chk("R2", "openDrain", 64'(openDrain), 64'(mOd));
      chk("R2", "schmittEn", 64'(schmittEn), 64'(mSmt));
      chk("R5", "periphSel", periphSel, sel);
      if (rdEn) begin
        if (addr == 8'h7C)      chk("R4", "level read", 64'(rdData), 64'(mRead(addr)));
        else if (addr == 8'h84) chk("R9", "wp status read", 64'(rdData), 64'(mRead(addr)));
        else if (addr == 8'h80) chk("R8", "wp mode read", 64'(rdData), 64'(mRead(addr)));
        else                    chk("R2", "status read", 64'(rdData), 64'(mRead(addr)));
      end
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk); #1;
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic rd(logic [7:0] a);
    rdEn = 1'b1; addr = a;
    @(posedge clk); #1;
    rdEn = 1'b0;
  endtask

  function automatic logic [31:0] lfsr(logic [31:0] s);
    return {s[30:0], s[31] ^ s[21] ^ s[1] ^ s[0]};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R1 watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    logic [31:0] seed;
    logic [7:0] addrs [16];
    addrs = '{8'h00, 8'h04, 8'h10, 8'h14, 8'h20, 8'h24, 8'h30, 8'h34,
              8'h40, 8'h50, 8'h54, 8'h60, 8'h64, 8'h70, 8'h74, 8'h80};
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    // R1: reset state
    chk("R1", "reset pullUp", 64'(pullUp), 64'hFFFF_FFFF);
    chk("R1", "reset pioOwn", 64'(pioOwn), 64'hFFFF_FFFF);
    chk("R1", "reset padOe", 64'(padOe), 64'h0);
    chk("R1", "reset periphSel", periphSel, 64'h0);
    @(posedge clk); #1;
    rd(8'h80); rd(8'h84); rd(8'h38);
    // R2/R3: output enable and output data
    wr(8'h10, 32'h0000_00FF); wr(8'h60, 32'h0000_000F);
    rd(8'h18); rd(8'h68);
    wr(8'h14, 32'h0000_0003); rd(8'h18);
    // R7: pull interlock both directions
    wr(8'h30, 32'h0000_0011); rd(8'h28); rd(8'h38);
    wr(8'h20, 32'h0000_0001); rd(8'h28); rd(8'h38);
    wr(8'h24, 32'h8000_0000); rd(8'h28);
    // R2 filter, R10 open drain
    wr(8'h40, 32'h0000_F000); wr(8'h44, 32'h0000_3000); rd(8'h48);
    wr(8'h50, 32'h0000_000C); rd(8'h58);
    wr(8'h64, 32'h0000_0004);
    // R5/R6: peripheral selection and hand-over
    wr(8'h70, 32'h0000_000A); wr(8'h74, 32'h0000_000C);
    wr(8'h04, 32'h0000_000E); rd(8'h08); rd(8'h70); rd(8'h74);
    wr(8'h00, 32'h0000_0002);
    wr(8'h78, 32'h0000_5555); rd(8'h78);
    // R4: synchroniser latency
    padIn = 32'hDEAD_BEEF;
    rd(8'h7C); rd(8'h7C); rd(8'h7C);
    padIn = 32'h1234_5678;
    rd(8'h7C); rd(8'h7C); rd(8'h7C);
    // R8: wrong key ignored, right key accepted
    wr(8'h80, 32'h1234_5601); rd(8'h80); rd(8'h84); rd(8'h84);
    wr(8'h80, {KEY, 8'h01}); rd(8'h80);
    // R9: blocked writes, status clear on read; R3 output still writable
    wr(8'h24, 32'hFFFF_FFFF); rd(8'h28); rd(8'h84); rd(8'h84);
    wr(8'h30, 32'h0000_0100); wr(8'h70, 32'hFFFF_FFFF); rd(8'h84);
    wr(8'h60, 32'h0000_0100); rd(8'h68); wr(8'h64, 32'h0000_0001);
    wr(8'h80, {KEY, 8'h00}); rd(8'h80);
    // mixed traffic
    seed = 32'hACE1_0001;
    for (int k = 0; k < 120; k++) begin
      seed = lfsr(seed);
      padIn = seed ^ 32'h5A5A_0F0F;
      if (seed[4]) begin
        logic [7:0] a;
        a = addrs[seed[11:8]];
        if (a == 8'h80) wr(a, {(seed[5] ? KEY : 24'h0F0F0F), 7'b0, seed[6]});
        else            wr(a, lfsr(seed));
      end else begin
        rd({1'b0, seed[15:12], 2'b00} + (seed[16] ? 8'h80 * 0 + 8'h04 : 8'h00));
      end
    end
    wr(8'h80, {KEY, 8'h00});
    rd(8'h84); rd(8'h84);
    @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule